// File: doc/BRIEF.md
# Idle-Synchronized Nibble Receiver

This block recovers 4-bit values from a single-wire serial line that carries no stop bit and no clock. The line rests high. A frame is a low start bit followed by four data bits, each lasting a fixed number of receiver clocks. The receiver locks onto a frame in two steps. It first proves that the line is idle by counting consecutive high cycles up to a threshold. It then takes the next falling edge as the start bit.

After that edge the receiver waits one bit time plus a small skew, so that its first sample lands inside the first data bit. It then samples once per bit time. The assembled nibble is presented with a one-cycle valid pulse. An abort input lets surrounding logic discard a frame whose capture has been disturbed. The receiver reports the discard with a one-cycle error pulse and goes back to hunting for a fresh idle stretch.

Top module: `idle_sync_nibble_rx`

## Requirements
- R1: `rx_i` passes through a two-flop synchronizer whose flops reset low. While reset is asserted, `valid_o` and `error_o` are 0 and `data_o` is 0.
- R2: A start bit is accepted only after at least IDLE_CHECKS*CHECK_CLKS consecutive synchronized high cycles, which is 49 by default. A frame preceded by one high cycle fewer produces neither a valid nor an error pulse.
- R3: The first data sample is taken BIT_CLKS+SAMPLE_SKEW clocks after start acceptance, and the later samples follow every BIT_CLKS clocks. If `rx_i` is first sampled low at clock edge n, `valid_o` is high right after edge n+2+SAMPLE_SKEW+4*BIT_CLKS, which is n+47 by default.
- R4: The first data bit after the start bit becomes `data_o[0]`, and the fourth becomes `data_o[3]`.
- R5: `valid_o` is high for exactly one cycle per received frame. `data_o` keeps the last received nibble until the next valid pulse.
- R6: If `abort_i` is high at a clock edge while a frame is being received, the frame is dropped. `error_o` is high for one cycle right after that edge and no valid pulse follows. An abort that coincides with the fourth sample still wins.
- R7: `abort_i` has no effect while the receiver is hunting for idle or waiting for a start bit. It causes no error and does not disturb idle qualification.
- R8: Idle qualification restarts from zero after every completed or aborted frame. High cycles seen during a frame do not count toward the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Receiver clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial line, idle high |
| abort_i | input | 1 | Discard the frame in progress |
| data_o | output | NIB_W | Last received nibble, first bit in bit 0 |
| valid_o | output | 1 | One-cycle pulse, new nibble on data_o |
| error_o | output | 1 | One-cycle pulse, frame aborted |

## Verification
A wrong bit timer or a wrong bit counter shows within the same frame. Either `valid_o` rises at a cycle other than n+47, or `data_o` holds a nibble whose bits are shifted or repeated. A wrong idle count shows as a frame accepted with one high cycle too few, or as a start taken right after a frame with no fresh idle stretch, each visible as an extra valid pulse. A wrong abort path shows on the next edge as a missing error pulse or as a valid pulse that should not appear.

// File: rtl/nrx_pkg.sv
package nrx_pkg;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_RECV = 1'b1
    } rx_state_e;

endpackage

// File: rtl/nrx_sync2.sv
module nrx_sync2 #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic s1_d, s1_q, s2_d, s2_q;

    always_comb begin
        s1_d = d_i;
        s2_d = s1_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s1_q <= RST_VAL;
            s2_q <= RST_VAL;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign q_o = s2_q;
endmodule

// File: rtl/nrx_idle_qual.sv
module nrx_idle_qual #(
    parameter int IDLE_CLKS = 49
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic line_i,
    output logic idle_ok_o
);
    localparam int CW = $clog2(IDLE_CLKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(IDLE_CLKS);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i || !line_i) begin
            cnt_d = '0;
        end else if (cnt_q < LIMIT) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign idle_ok_o = (cnt_q >= LIMIT);
endmodule

// File: rtl/nrx_shift.sv
module nrx_shift #(
    parameter int W = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clear_i,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] word_next_o
);
    logic [W-1:0] word_d, word_q;

    always_comb begin
        word_next_o = {bit_i, word_q[W-1:1]};
        word_d      = word_q;
        if (clear_i)      word_d = '0;
        else if (shift_i) word_d = word_next_o;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) word_q <= '0;
        else         word_q <= word_d;
    end
endmodule

// File: rtl/idle_sync_nibble_rx.sv
module idle_sync_nibble_rx
    import nrx_pkg::*;
#(
    parameter int NIB_W       = 4,
    parameter int BIT_CLKS    = 10,
    parameter int SAMPLE_SKEW = 5,
    parameter int IDLE_CHECKS = 7,
    parameter int CHECK_CLKS  = 7
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rx_i,
    input  logic             abort_i,
    output logic [NIB_W-1:0] data_o,
    output logic             valid_o,
    output logic             error_o
);
    localparam int IDLE_CLKS = IDLE_CHECKS * CHECK_CLKS;
    localparam int FIRST     = BIT_CLKS + SAMPLE_SKEW;
    localparam int TMAX      = (FIRST > BIT_CLKS) ? FIRST : BIT_CLKS;
    localparam int TW        = $clog2(TMAX) + 1;
    localparam int BW        = (NIB_W > 1) ? $clog2(NIB_W) : 1;
    localparam logic [TW-1:0] T_FIRST = TW'(FIRST - 1);
    localparam logic [TW-1:0] T_BIT   = TW'(BIT_CLKS - 1);
    localparam logic [BW-1:0] B_LAST  = BW'(NIB_W - 1);

    typedef struct packed {
        rx_state_e        state;
        logic [TW-1:0]    timer;
        logic [BW-1:0]    bits;
        logic [NIB_W-1:0] data;
        logic             valid;
        logic             error;
    } rx_regs_t;

    rx_regs_t r_d, r_q;

    logic             line_s;
    logic             idle_ok;
    logic             in_frame;
    logic             shift_en;
    logic             shift_clr;
    logic [NIB_W-1:0] word_next;

    nrx_sync2 #(.RST_VAL(1'b0)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (rx_i),
        .q_o    (line_s)
    );

    nrx_idle_qual #(.IDLE_CLKS(IDLE_CLKS)) u_idle (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clear_i   (in_frame),
        .line_i    (line_s),
        .idle_ok_o (idle_ok)
    );

    nrx_shift #(.W(NIB_W)) u_shift (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .clear_i     (shift_clr),
        .shift_i     (shift_en),
        .bit_i       (line_s),
        .word_next_o (word_next)
    );

    assign in_frame = (r_q.state == ST_RECV);

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        r_d.error = 1'b0;
        shift_en  = 1'b0;
        shift_clr = 1'b0;
        unique case (r_q.state)
            ST_HUNT: begin
                if (idle_ok && !line_s) begin
                    r_d.state = ST_RECV;
                    r_d.timer = T_FIRST;
                    r_d.bits  = '0;
                    shift_clr = 1'b1;
                end
            end
            ST_RECV: begin
                if (abort_i) begin
                    r_d.state = ST_HUNT;
                    r_d.error = 1'b1;
                end else if (r_q.timer == '0) begin
                    shift_en  = 1'b1;
                    r_d.timer = T_BIT;
                    if (r_q.bits == B_LAST) begin
                        r_d.state = ST_HUNT;
                        r_d.valid = 1'b1;
                        r_d.data  = word_next;
                    end else begin
                        r_d.bits = r_q.bits + 1'b1;
                    end
                end else begin
                    r_d.timer = r_q.timer - 1'b1;
                end
            end
            default: r_d.state = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.state <= ST_HUNT;
            r_q.timer <= '0;
            r_q.bits  <= '0;
            r_q.data  <= '0;
            r_q.valid <= 1'b0;
            r_q.error <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign data_o  = r_q.data;
    assign valid_o = r_q.valid;
    assign error_o = r_q.error;
endmodule

// File: rtl/nrx_checker.sv
module nrx_checker (
    input logic clk_i,
    input logic rst_ni,
    input logic abort_i,
    input logic valid_o,
    input logic error_o,
    input logic in_frame,
    input logic idle_ok
);
    // R2: a frame only begins from a qualified idle stretch
    a_r2_start_after_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(in_frame) |-> $past(idle_ok));

    // R5: the valid pulse lasts one cycle
    a_r5_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> !valid_o);

    // R5: a valid pulse closes a frame
    a_r5_valid_ends_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> ($past(in_frame) && !in_frame));

    // R6: an error pulse comes only from an abort inside a frame
    a_r6_error_from_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
        error_o |-> ($past(in_frame) && $past(abort_i) && !in_frame));

    // R6: the error pulse lasts one cycle and never joins a valid pulse
    a_r6_error_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        error_o |=> !error_o);
    a_r6_no_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(error_o && valid_o));

    // R7: an abort outside a frame raises no error
    a_r7_abort_outside: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (abort_i && !in_frame) |=> !error_o);

    // R8: idle qualification stays cleared during a frame
    a_r8_no_qual_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_frame |-> !idle_ok);
endmodule

bind idle_sync_nibble_rx nrx_checker u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .abort_i  (abort_i),
    .valid_o  (valid_o),
    .error_o  (error_o),
    .in_frame (in_frame),
    .idle_ok  (idle_ok)
);

// File: tb/idle_sync_nibble_rx_tb_top.sv
`timescale 1ns/1ps
module idle_sync_nibble_rx_tb_top;
    localparam int NIB_W  = 4;
    localparam int BIT    = 10;
    localparam int SKEW   = 5;
    localparam int IDLE   = 49;
    localparam int LAT    = 3 + SKEW + 4 * BIT;   // R3: negedge count from start drive to visible valid

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx = 1'b0;
    logic abort = 1'b0;
    logic [NIB_W-1:0] data;
    logic valid, error;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    int vcount = 0;
    int ecount = 0;
    int last_vcyc = -1;
    int last_ecyc = -1;
    int start_cyc = 0;

    always #10 clk = ~clk;

    idle_sync_nibble_rx dut_i (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .rx_i    (rx),
        .abort_i (abort),
        .data_o  (data),
        .valid_o (valid),
        .error_o (error)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (valid) begin vcount++; last_vcyc = cyc; end
        if (error) begin ecount++; last_ecyc = cyc; end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx = v;
        end
    endtask

    task automatic frame_core(input logic [NIB_W-1:0] nib, input int pre, input int hi, input int tail);
        drive(1'b0, pre);
        drive(1'b1, hi);
        @(negedge clk);
        rx = 1'b0;
        start_cyc = cyc;
        drive(1'b0, BIT - 1);
        for (int b = 0; b < NIB_W; b++) drive(nib[b], BIT);
        drive(1'b1, tail);
    endtask

    // ab < 0: no abort; else abort high at the negedge ab clocks after the start drive
    task automatic send(input logic [NIB_W-1:0] nib, input int pre, input int hi,
                        input int tail, input int ab);
        fork
            frame_core(nib, pre, hi, tail);
            begin
                if (ab >= 0) begin
                    repeat (pre + hi + 1 + ab) @(negedge clk);
                    abort = 1'b1;
                    @(negedge clk);
                    abort = 1'b0;
                end
            end
        join
    endtask

    task automatic run_all();
        int v0, e0;
        logic [NIB_W-1:0] held;
        repeat (3) @(negedge clk);
        chk(valid == 1'b0, "R1 reset valid", int'(valid), 0);
        chk(error == 1'b0, "R1 reset error", int'(error), 0);
        chk(data == '0,   "R1 reset data", int'(data), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R3 R4 R5: every nibble with exactly the minimum idle stretch
        for (int n = 0; n < 16; n++) begin
            v0 = vcount; e0 = ecount;
            send(NIB_W'(n), 60, IDLE, 5, -1);
            chk(vcount == v0 + 1, "R2 accepted at threshold", vcount - v0, 1);
            chk(data == NIB_W'(n), "R4 nibble bit order", int'(data), n);
            chk(last_vcyc == start_cyc + LAT, "R3 valid latency", last_vcyc - start_cyc, LAT);
            chk(ecount == e0, "R5 no error on clean frame", ecount - e0, 0);
            chk(valid == 1'b0, "R5 valid dropped", int'(valid), 0);
        end

        // R2: one idle cycle short
        held = data;
        v0 = vcount; e0 = ecount;
        send(4'hA, 60, IDLE - 1, 5, -1);
        chk(vcount == v0, "R2 short idle rejected", vcount - v0, 0);
        chk(ecount == e0, "R2 short idle no error", ecount - e0, 0);
        chk(data == held, "R5 data held", int'(data), int'(held));

        // R8: long high across a frame does not requalify without fresh idle
        v0 = vcount;
        send(4'hF, 60, IDLE, 20, -1);
        chk(vcount == v0 + 1, "R8 first frame", vcount - v0, 1);
        send(4'h5, 0, 0, 5, -1);
        chk(vcount == v0 + 1, "R8 no fresh idle", vcount - v0, 1);
        chk(data == 4'hF, "R8 data unchanged", int'(data), 15);

        // R6: abort in the middle of a frame
        v0 = vcount; e0 = ecount;
        send(4'h6, 60, IDLE, 5, 20);
        chk(ecount == e0 + 1, "R6 abort error", ecount - e0, 1);
        chk(last_ecyc == start_cyc + 21, "R6 error timing", last_ecyc - start_cyc, 21);
        chk(vcount == v0, "R6 aborted frame no valid", vcount - v0, 0);
        chk(data == 4'hF, "R6 data kept", int'(data), 15);

        // R8: retry after abort
        send(4'h9, 60, IDLE, 5, -1);
        chk(vcount == v0 + 1, "R8 retry accepted", vcount - v0, 1);
        chk(data == 4'h9, "R8 retry data", int'(data), 9);

        // R6: abort on the fourth sample edge
        v0 = vcount; e0 = ecount;
        send(4'h3, 60, IDLE, 5, LAT - 1);
        chk(ecount == e0 + 1, "R6 late abort error", ecount - e0, 1);
        chk(last_ecyc == start_cyc + LAT, "R6 late abort timing", last_ecyc - start_cyc, LAT);
        chk(vcount == v0, "R6 late abort no valid", vcount - v0, 0);

        // R7: abort while hunting has no effect
        v0 = vcount; e0 = ecount;
        drive(1'b0, 60);
        drive(1'b1, 30);
        @(negedge clk);
        rx = 1'b1;
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        rx = 1'b1;
        drive(1'b1, 2);
        chk(ecount == e0, "R7 abort in hunt no error", ecount - e0, 0);
        send(4'hC, 0, 20, 5, -1);
        chk(vcount == v0 + 1, "R7 idle kept", vcount - v0, 1);
        chk(data == 4'hC, "R7 data", int'(data), 12);
        chk(ecount == e0, "R7 no error", ecount - e0, 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule